// File: doc/BRIEF.md
# Two-Channel PWM Timebase with Power-of-Two Prescaler

This block produces two pulse-width modulated outputs that share one timebase. A write port carries four kinds of setting: the period length in counter ticks, a clock divider request, and one compare value for each channel. The input clock, nominally 100 MHz, is divided by a power of two between 1 and 128. Each divided tick advances a 16-bit up-counter that runs from zero to the period minus one and then wraps.

A channel output is high while the counter is below that channel's compare value, so the compare value sets the duty in ticks. The block also gives back the programmed settings and the output frequency that follows from them, so firmware can read back what the hardware accepted after clamping or rounding. Period and divider changes wait for the current cycle to end, so the output never shows a shortened cycle.

Top module: `pwm2_timebase`

## Requirements
- R1: After a synchronous active-low reset, the period read-back is 999 (1000 ticks), the divider index is 0, both compare values are 0, the frequency read-back is 100000 and the counter is 0.
- R2: A write with wr_sel = 0 and a value N in 1..65535 sets the period read-back to N-1 in the cycle after the write.
- R3: A period request above 65535 is stored as 65535 ticks, read back as 65534.
- R4: A period request of 0 is ignored: the period, the divider and both compare values keep their values.
- R5: Every accepted period write sets both compare values to 0 in the same update.
- R6: A write with wr_sel = 1 and a value r ≥ 1 sets the divider index k (divider 2^k, k in 0..7) to the largest k with 2^k ≤ r, capped at 7. A request of 0 leaves the index unchanged. A request that maps to the current index changes nothing.
- R7: The frequency read-back equals floor(floor(100000000 / 2^k) / P), where k is the programmed index and P the programmed period in ticks.
- R8: The counter advances by one every 2^k input clock cycles, using the active index. The tick divider starts again from zero whenever the active index changes.
- R9: A new period or divider becomes active only when the counter wraps from the active period minus one to 0. The counter never goes above the active period minus one.
- R10: Output pwm_a (or pwm_b) is high exactly when the counter is strictly less than the compare value for channel A (or B). A compare value of 0 keeps the output low.
- R11: Writes with wr_sel = 2 or 3 load bits 15:0 of wr_data into the compare value of channel A or B. The new value takes effect in the next cycle and leaves the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, nominally 100 MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Setting write strobe, one cycle |
| wr_sel | input | 2 | 0 period, 1 divider request, 2 compare A, 3 compare B |
| wr_data | input | 32 | Write value |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| tb_count | output | 16 | Current timebase counter value |
| period_m1_rd | output | 16 | Programmed period minus one |
| div_idx_rd | output | 3 | Programmed divider index k (divider 2^k) |
| cmp_a_rd | output | 16 | Channel A compare value |
| cmp_b_rd | output | 16 | Channel B compare value |
| freq_rd | output | 32 | Resulting output frequency in Hz |

## Verification
The outputs are tried with a zero compare, which must stay low, and with a compare inside the period, which gives a partial duty. They are also tried with a compare beyond the period, which must stay high. A one-tick period, where the counter stays at zero, is tried as well. Divider requests of exact powers of two, values between powers, values above 128 and zero tell apart rounding down, capping and rejection. The tests of the frequency read-back use different indices and periods. A large period is followed at once by a short one before the wrap, which shows that only the setting present at the wrap becomes active. A change of divider in the middle of a cycle shows that the tick rate switches only at the wrap boundary.

// File: rtl/pwmtb_pkg.sv
`timescale 1ns/1ps
// Shared types for the PWM timebase: the write-target selector.
package pwmtb_pkg;
    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_PRESC  = 2'd1,
        SEL_CMPA   = 2'd2,
        SEL_CMPB   = 2'd3
    } pwm_sel_e;
endpackage

// File: rtl/pwmtb_cfg.sv
`timescale 1ns/1ps
// Setting registers: accepts writes, clamps periods, rejects zero requests,
// rounds divider requests down to a power of two and clears compares on
// period writes. Assumes wr_en is a single-cycle strobe in the clk domain.
module pwmtb_cfg #(
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 32,
    parameter int DIV_STEPS  = 8,
    parameter int RST_PERIOD = 1000,
    parameter int NCH        = 2,
    localparam int IDX_W     = $clog2(DIV_STEPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [CNT_W-1:0]          per_q,
    output logic [IDX_W-1:0]          idx_q,
    output logic [NCH-1:0][CNT_W-1:0] cmp_q
);
    import pwmtb_pkg::*;

    localparam logic [DATA_W-1:0] PER_MAX_W = {{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] per_clamped;
    logic [IDX_W-1:0] req_idx;
    logic             data_zero;

    // Clamp the requested period to the counter range.
    always_comb begin
        per_clamped = (wr_data > PER_MAX_W) ? {CNT_W{1'b1}} : wr_data[CNT_W-1:0];
    end

    // Pick the largest power-of-two divider not above the request.
    always_comb begin
        req_idx = '0;
        for (int i = 0; i < DIV_STEPS; i++) begin
            if (wr_data >= (DATA_W'(1) << i)) req_idx = IDX_W'(i);
        end
    end

    assign data_zero = (wr_data == '0);

    // Apply accepted writes to the programmed settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= CNT_W'(RST_PERIOD);
            idx_q <= '0;
            cmp_q <= '0;
        end else if (wr_en) begin
            case (pwm_sel_e'(wr_sel))
                SEL_PERIOD: begin
                    if (!data_zero) begin
                        per_q <= per_clamped;
                        cmp_q <= '0;
                    end
                end
                SEL_PRESC: begin
                    if (!data_zero && (req_idx != idx_q)) idx_q <= req_idx;
                end
                SEL_CMPA: cmp_q[0] <= wr_data[CNT_W-1:0];
                SEL_CMPB: cmp_q[NCH-1] <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwmtb_presc.sv
`timescale 1ns/1ps
// Clock prescaler: issues one tick every 2^idx input cycles. Assumes idx
// changes only on a tick, so the count restarts from zero with each new index.
module pwmtb_presc #(
    parameter int DIV_STEPS = 8,
    localparam int IDX_W    = $clog2(DIV_STEPS),
    localparam int PRE_W    = (DIV_STEPS > 1) ? DIV_STEPS - 1 : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] act_idx,
    output logic             tick,
    output logic [PRE_W-1:0] pre_q
);
    logic [PRE_W-1:0] limit;

    // Last count value before a tick for the active divider.
    assign limit = PRE_W'(((PRE_W+1)'(1) << act_idx) - (PRE_W+1)'(1));
    assign tick  = (pre_q == limit);

    // Count input cycles and restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/pwmtb_counter.sv
`timescale 1ns/1ps
// Period counter: counts ticks from 0 to the active period minus one. It loads
// the programmed period and divider into the active copies only at the wrap.
// Assumes prog_per is never zero.
module pwmtb_counter #(
    parameter int CNT_W      = 16,
    parameter int DIV_STEPS  = 8,
    parameter int RST_PERIOD = 1000,
    localparam int IDX_W     = $clog2(DIV_STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] prog_per,
    input  logic [IDX_W-1:0] prog_idx,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] act_m1_q,
    output logic [IDX_W-1:0] act_idx_q
);
    logic at_end;

    assign at_end = (cnt_q == act_m1_q);

    // Advance on each tick; at the end, wrap and take the new settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            act_m1_q  <= CNT_W'(RST_PERIOD - 1);
            act_idx_q <= '0;
        end else if (tick) begin
            if (at_end) begin
                cnt_q     <= '0;
                act_m1_q  <= prog_per - CNT_W'(1);
                act_idx_q <= prog_idx;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pwmtb_cmp.sv
`timescale 1ns/1ps
// Channel comparators: one output per channel, high while the count is below
// that channel's compare value. Purely combinational from registered inputs.
module pwmtb_cmp #(
    parameter int CNT_W = 16,
    parameter int NCH   = 2
) (
    input  logic [CNT_W-1:0]          cnt,
    input  logic [NCH-1:0][CNT_W-1:0] cmp,
    output logic [NCH-1:0]            pwm
);
    // One strict less-than comparator for each channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign pwm[ch] = (cnt < cmp[ch]);
    end
endmodule

// File: rtl/pwm2_timebase.sv
`timescale 1ns/1ps
// Two-channel PWM timebase top: setting registers, prescaler, period counter,
// comparators and a frequency read-back. Assumes a single clock domain and
// that CLK_HZ fits in FREQ_W bits.
module pwm2_timebase #(
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 32,
    parameter int DIV_STEPS  = 8,
    parameter int RST_PERIOD = 1000,
    parameter int CLK_HZ     = 100_000_000,
    parameter int FREQ_W     = 32,
    localparam int IDX_W     = $clog2(DIV_STEPS),
    localparam int PRE_W     = (DIV_STEPS > 1) ? DIV_STEPS - 1 : 1,
    localparam int NCH       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic [CNT_W-1:0]  tb_count,
    output logic [CNT_W-1:0]  period_m1_rd,
    output logic [IDX_W-1:0]  div_idx_rd,
    output logic [CNT_W-1:0]  cmp_a_rd,
    output logic [CNT_W-1:0]  cmp_b_rd,
    output logic [FREQ_W-1:0] freq_rd
);
    localparam logic [FREQ_W-1:0] CLK_V = FREQ_W'(CLK_HZ);

    logic [CNT_W-1:0]          per_q;
    logic [IDX_W-1:0]          idx_q;
    logic [NCH-1:0][CNT_W-1:0] cmp_q;
    logic                      tick;
    logic [PRE_W-1:0]          pre_q;
    logic [CNT_W-1:0]          cnt_q;
    logic [CNT_W-1:0]          act_m1_q;
    logic [IDX_W-1:0]          act_idx_q;
    logic [NCH-1:0]            pwm;

    pwmtb_cfg #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_STEPS(DIV_STEPS),
        .RST_PERIOD(RST_PERIOD), .NCH(NCH)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .per_q(per_q), .idx_q(idx_q), .cmp_q(cmp_q)
    );

    pwmtb_presc #(.DIV_STEPS(DIV_STEPS)) u_presc (
        .clk(clk), .rst_n(rst_n), .act_idx(act_idx_q), .tick(tick), .pre_q(pre_q)
    );

    pwmtb_counter #(
        .CNT_W(CNT_W), .DIV_STEPS(DIV_STEPS), .RST_PERIOD(RST_PERIOD)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .prog_per(per_q),
        .prog_idx(idx_q), .cnt_q(cnt_q), .act_m1_q(act_m1_q), .act_idx_q(act_idx_q)
    );

    pwmtb_cmp #(.CNT_W(CNT_W), .NCH(NCH)) u_cmp (
        .cnt(cnt_q), .cmp(cmp_q), .pwm(pwm)
    );

    // Read-back of programmed settings and the derived output frequency.
    assign pwm_a        = pwm[0];
    assign pwm_b        = pwm[1];
    assign tb_count     = cnt_q;
    assign period_m1_rd = per_q - CNT_W'(1);
    assign div_idx_rd   = idx_q;
    assign cmp_a_rd     = cmp_q[0];
    assign cmp_b_rd     = cmp_q[1];
    assign freq_rd      = (CLK_V >> idx_q) / FREQ_W'(per_q);
endmodule

// File: rtl/pwmtb_chk.sv
`timescale 1ns/1ps
// Property checker for the PWM timebase, bound into every pwm2_timebase.
module pwmtb_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int PRE_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              tick,
    input logic [PRE_W-1:0]  pre_q,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  act_m1,
    input logic [IDX_W-1:0]  act_idx,
    input logic [CNT_W-1:0]  period_m1_rd,
    input logic [IDX_W-1:0]  div_idx_rd,
    input logic [CNT_W-1:0]  cmp_a_rd,
    input logic [CNT_W-1:0]  cmp_b_rd
);
    localparam logic [DATA_W-1:0] PER_MAX_W = {{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_m1); // R9

    AST_ACT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_m1) || !$stable(act_idx) |-> cnt == '0); // R9

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_idx) |-> pre_q == '0); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R8

    AST_PER_CLEARS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd0 && wr_data != '0 |=> cmp_a_rd == '0 && cmp_b_rd == '0); // R5

    AST_PER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd0 && wr_data > PER_MAX_W |=> period_m1_rd == {{(CNT_W-1){1'b1}}, 1'b0}); // R3

    AST_PER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd0 && wr_data == '0 |=> $stable(period_m1_rd) && $stable(cmp_a_rd)); // R4

    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd1 && wr_data == '0 |=> $stable(div_idx_rd)); // R6

    AST_CMPA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd2 |=> cmp_a_rd == $past(wr_data[CNT_W-1:0]) && $stable(cmp_b_rd)); // R11
endmodule

bind pwm2_timebase pwmtb_chk #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PRE_W(PRE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .pre_q(pre_q), .cnt(cnt_q), .act_m1(act_m1_q), .act_idx(act_idx_q),
    .period_m1_rd(period_m1_rd), .div_idx_rd(div_idx_rd),
    .cmp_a_rd(cmp_a_rd), .cmp_b_rd(cmp_b_rd)
);

// File: tb/sim_pwm2_timebase.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected read-backs for each write; a
// monitor pops them and also steps a cycle model of counter and outputs.
module sim_pwm2_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pwm_a, pwm_b;
    logic [15:0] tb_count, period_m1_rd, cmp_a_rd, cmp_b_rd;
    logic [2:0]  div_idx_rd;
    logic [31:0] freq_rd;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct { int per_m1; int idx; int ca; int cb; int fq; } exp_t;
    exp_t q[$];

    // driver shadow of programmed settings
    int d_per = 1000, d_idx = 0, d_ca = 0, d_cb = 0;

    always #4 clk = ~clk;

    pwm2_timebase u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .tb_count(tb_count), .period_m1_rd(period_m1_rd),
        .div_idx_rd(div_idx_rd), .cmp_a_rd(cmp_a_rd), .cmp_b_rd(cmp_b_rd), .freq_rd(freq_rd)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int map_idx(input longint r, input int cur);
        int k;
        k = 0;
        if (r == 0) return cur;
        for (int i = 0; i < 8; i++) if (r >= (64'd1 << i)) k = i;
        return k;
    endfunction

    function automatic int exp_freq(input int idx, input int per);
        return (100000000 >> idx) / per;
    endfunction

    // Driver: one-cycle write plus the expected read-back item.
    task automatic do_wr(input int sel, input longint data);
        exp_t e;
        @(posedge clk); #2;
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 32'(data);
        case (sel)
            0: if (data != 0) begin
                   d_per = (data > 65535) ? 65535 : int'(data);
                   d_ca = 0; d_cb = 0;
               end
            1: d_idx = map_idx(data, d_idx);
            2: d_ca = int'(data) & 16'hFFFF;
            default: d_cb = int'(data) & 16'hFFFF;
        endcase
        e.per_m1 = d_per - 1; e.idx = d_idx; e.ca = d_ca; e.cb = d_cb;
        e.fq = exp_freq(d_idx, d_per);
        q.push_back(e);
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Monitor: capture inputs at the edge, compare half a cycle later.
    bit          s_rst, s_we;
    int          s_sel;
    longint      s_data;
    always @(posedge clk) begin
        s_rst = rst_n; s_we = wr_en; s_sel = int'(wr_sel); s_data = longint'(wr_data);
    end

    int m_per = 1000, m_idx = 0, m_ca = 0, m_cb = 0;
    int m_act_m1 = 999, m_act_idx = 0, m_pre = 0, m_cnt = 0;

    always @(negedge clk) begin : mon
        exp_t e;
        if (!s_rst) begin
            m_per = 1000; m_idx = 0; m_ca = 0; m_cb = 0;
            m_act_m1 = 999; m_act_idx = 0; m_pre = 0; m_cnt = 0;
        end else begin
            // timebase step with settings held before this edge (R8, R9)
            if (m_pre == (1 << m_act_idx) - 1) begin
                m_pre = 0;
                if (m_cnt == m_act_m1) begin
                    m_cnt = 0; m_act_m1 = m_per - 1; m_act_idx = m_idx;
                end else m_cnt++;
            end else m_pre++;
            if (s_we) begin
                case (s_sel)
                    0: if (s_data != 0) begin
                           m_per = (s_data > 65535) ? 65535 : int'(s_data);
                           m_ca = 0; m_cb = 0;
                       end
                    1: m_idx = map_idx(s_data, m_idx);
                    2: m_ca = int'(s_data) & 16'hFFFF;
                    default: m_cb = int'(s_data) & 16'hFFFF;
                endcase
                if (q.size() == 0) chk(1'b0, "scoreboard R2", 0, 1);
                else begin
                    e = q.pop_front();
                    chk(int'(period_m1_rd) == e.per_m1, "R2/R3/R4 period read-back", period_m1_rd, e.per_m1);
                    chk(int'(div_idx_rd) == e.idx, "R6 divider index", div_idx_rd, e.idx);
                    chk(int'(cmp_a_rd) == e.ca, "R5/R11 compare A", cmp_a_rd, e.ca);
                    chk(int'(cmp_b_rd) == e.cb, "R5/R11 compare B", cmp_b_rd, e.cb);
                    chk(int'(freq_rd) == e.fq, "R7 frequency", freq_rd, e.fq);
                end
            end
            chk(int'(tb_count) == m_cnt, "R8/R9 counter", tb_count, m_cnt);
            chk(pwm_a == (m_cnt < m_ca), "R10 pwm_a", pwm_a, (m_cnt < m_ca));
            chk(pwm_b == (m_cnt < m_cb), "R10 pwm_b", pwm_b, (m_cnt < m_cb));
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(period_m1_rd == 16'd999, "R1 period", period_m1_rd, 999);
        chk(div_idx_rd == 3'd0, "R1 divider", div_idx_rd, 0);
        chk(cmp_a_rd == 16'd0 && cmp_b_rd == 16'd0, "R1 compares", cmp_a_rd, 0);
        chk(freq_rd == 32'd100000, "R1 frequency", freq_rd, 100000);
        chk(!pwm_a && !pwm_b, "R1 outputs low", pwm_a, 0);

        do_wr(2, 3);             // R11 compare A during default period
        do_wr(0, 5);             // R2, R5: period 5 clears compares
        run(1010);               // wait for the 1000-tick wrap (R9)
        do_wr(2, 2);             // R10 partial duty on A
        do_wr(3, 0);             // R10 zero compare on B
        run(20);
        do_wr(3, 7);             // R10 compare beyond period: always high
        run(20);
        do_wr(1, 3);             // R6 rounds 3 down to divider 2
        run(40);
        do_wr(1, 0);             // R6 zero request ignored
        do_wr(0, 0);             // R4 zero period ignored
        run(10);
        do_wr(1, 1000);          // R6 capped at divider 128
        run(1300);
        do_wr(0, 70000);         // R3 clamp, R5 clear
        do_wr(0, 3);             // R9 only the last setting at the wrap counts
        do_wr(1, 1);             // R6 back to divider 1
        do_wr(2, 1);
        run(1000);
        do_wr(1, 2);             // R6 exact power of two
        do_wr(1, 3);             // R6 same index: no change
        do_wr(3, 2);
        run(40);
        do_wr(0, 1);             // R2 one-tick period
        do_wr(2, 1);             // R10 compare 1 with counter held at 0
        run(30);
        do_wr(1, 16);            // R6, R8 divider 16
        do_wr(0, 4);
        do_wr(2, 3);
        run(200);
        @(negedge clk);
        chk(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule